// File: doc/BRIEF.md
# Configurable asynchronous serial frame decoder

This block watches one asynchronous serial line and turns each frame it sees into a short stream of typed events. Software or a downstream trace buffer uses these events to annotate a captured line: one event for the start bit, one for the assembled data word, one for the parity bit when parity is present, one for each stop sample, and error events for a bad start, a bad stop or a parity mismatch. The configuration inputs are static while a frame is in flight. They set the bit period in clock cycles, the data width (5 to 9 bits), the parity mode, the stop length, the bit order, and two kinds of polarity inversion.

The line first passes a two-flop synchronizer, and the selected line inversion is applied to it. The control is a six-state machine. `S_IDLE` waits for a falling edge of the normalised line and then goes to `S_START`. `S_START` samples half a bit period later. A low sample goes to `S_DATA`. A high sample reports an invalid start and returns to `S_IDLE`. `S_DATA` samples once per bit period until the last data bit. It then goes to `S_PARITY` when parity is enabled, or to `S_STOP1` otherwise. `S_PARITY` samples once and goes to `S_STOP1`. `S_STOP1` samples at the middle of the stop interval. It goes to `S_STOP2` when two stop bits are configured and the sample was good, and otherwise returns to `S_IDLE`. `S_STOP2` samples the second stop bit and returns to `S_IDLE`.

Every event appears on a registered output as a one-cycle `evt_valid` pulse. The pulse comes with a code, a 9-bit value and the direction tag copied from `dir_in`.

Top module: `uart_frame_annotator`

## Requirements
- R1: While the synchronized, inversion-corrected line stays at its idle level (high), no event is produced. A frame begins only on a high-to-low transition.
- R2: The start bit is sampled cfg_clks_per_bit/2 cycles after the detected edge. A low sample gives a start event (code 0, value 0). A high sample gives an invalid-start event (code 4, value 1), and the decoder then returns to hunting for the next edge with no further events for that frame.
- R3: cfg_data_bits (5 to 9) data bits are sampled one bit period apart, LSB-first by default. They are reported as one data event (code 1) whose 9-bit value is zero-extended above the configured width.
- R4: When cfg_msb_first is 1, the first received data bit is the most significant bit of the word.
- R5: cfg_parity selects 0 none, 1 odd, 2 even, 3 mark (always 1) or 4 space (always 0). Odd and even count the data ones together with the parity bit. When parity is enabled, a parity event (code 2) carries the received parity bit. Mode 0 produces no parity event.
- R6: When the received parity differs from the expected value, a parity-error event (code 6) follows the parity event on the next cycle. evt_par_exp carries the expected value and evt_par_act the received value.
- R7: cfg_stop selects the stop length: 0 is half a bit, 1 is one bit, 2 is one and a half bits, and 3 is two bits. Each stop event (code 3, value 1) is sampled at the middle of its stop interval. Two-bit stop produces two stop events. A new start edge is accepted right after the stop interval.
- R8: A stop sample that is low gives an invalid-stop event (code 5, value 0). The frame then ends without a second stop sample.
- R9: When cfg_line_inv is 1, the line idles low and every field is complemented before decoding.
- R10: When cfg_data_inv is 1, only the data and parity bits are complemented. Start and stop keep their normal polarity.
- R11: Every event carries evt_dir equal to dir_in (0 receive line, 1 transmit line).
- R12: Each event is a single-cycle evt_valid pulse. Within a frame, events come in the order start, data, parity, parity error, stop. Only codes 0 to 6 are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Asynchronous serial line |
| cfg_clks_per_bit | input | CPB_W | Bit period in clock cycles (at least 4) |
| cfg_data_bits | input | 4 | Data width, 5 to 9 |
| cfg_parity | input | 3 | Parity mode (0 none, 1 odd, 2 even, 3 mark, 4 space) |
| cfg_stop | input | 2 | Stop length (0 half, 1 one, 2 one and a half, 3 two) |
| cfg_msb_first | input | 1 | 1 selects MSB-first data order |
| cfg_line_inv | input | 1 | Whole-line inversion |
| cfg_data_inv | input | 1 | Data and parity inversion only |
| dir_in | input | 1 | Direction tag copied into events |
| evt_valid | output | 1 | Event strobe |
| evt_code | output | 3 | Event type |
| evt_data | output | 9 | Event value |
| evt_dir | output | 1 | Direction tag of the event |
| evt_par_exp | output | 1 | Expected parity (parity and parity-error events) |
| evt_par_act | output | 1 | Received parity (parity and parity-error events) |

## Verification
The embedded assertions check the following on every cycle:
- the machine holds in `S_IDLE` while no edge arrives;
- start and invalid-start values are fixed at 0 and 1;
- data words never have bits set above the configured width;
- a parity error always follows a parity event and carries differing expected and received values;
- an invalid stop leaves the machine idle;
- the direction tag tracks its input, and only legal codes appear.

Only the bench scenarios can show the parts that depend on a whole frame: the decoded values for each width, order and parity mode; the effect of both inversions; mid-bit sampling that rejects a short start glitch; and back-to-back frames after half-bit and one-and-a-half-bit stops.

// File: rtl/uaf_pkg.sv
package uaf_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } par_mode_t;

    typedef enum logic [1:0] {
        STOP_HALF     = 2'd0,
        STOP_ONE      = 2'd1,
        STOP_ONE_HALF = 2'd2,
        STOP_TWO      = 2'd3
    } stop_len_t;

    typedef enum logic [2:0] {
        EV_START     = 3'd0,
        EV_DATA      = 3'd1,
        EV_PARITY    = 3'd2,
        EV_STOP      = 3'd3,
        EV_BAD_START = 3'd4,
        EV_BAD_STOP  = 3'd5,
        EV_PAR_ERR   = 3'd6
    } evt_code_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP1,
        S_STOP2
    } dec_state_t;

    localparam int unsigned WORD_W = 9;

endpackage

// File: rtl/uaf_line_sync.sv
module uaf_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic invert,
    output logic lvl,
    output logic fall
);
    logic s1, s2, prev;

    // Inversion is applied before the flops so the reset (idle) value is always 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            prev <= 1'b1;
        end else begin
            s1   <= line_in ^ invert;
            s2   <= s1;
            prev <= s2;
        end
    end

    assign lvl  = s2;
    assign fall = prev & ~s2;
endmodule

// File: rtl/uaf_bit_timer.sv
module uaf_bit_timer #(
    parameter int unsigned CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign tick = (cnt == '0);
endmodule

// File: rtl/uaf_parity.sv
module uaf_parity
    import uaf_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  par_mode_t         mode,
    output logic              exp_bit
);
    always_comb begin
        unique case (mode)
            PAR_ODD:   exp_bit = ~^word;
            PAR_EVEN:  exp_bit = ^word;
            PAR_MARK:  exp_bit = 1'b1;
            PAR_SPACE: exp_bit = 1'b0;
            default:   exp_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_frame_annotator.sv
module uart_frame_annotator
    import uaf_pkg::*;
#(
    parameter int unsigned CPB_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic [CPB_W-1:0] cfg_clks_per_bit,
    input  logic [3:0]       cfg_data_bits,
    input  logic [2:0]       cfg_parity,
    input  logic [1:0]       cfg_stop,
    input  logic             cfg_msb_first,
    input  logic             cfg_line_inv,
    input  logic             cfg_data_inv,
    input  logic             dir_in,
    output logic             evt_valid,
    output logic [2:0]       evt_code,
    output logic [8:0]       evt_data,
    output logic             evt_dir,
    output logic             evt_par_exp,
    output logic             evt_par_act
);
    localparam int unsigned CNT_W = CPB_W + 1;

    dec_state_t st, st_nx;
    logic lvl, fall, tick, ld;
    logic [CNT_W-1:0] ld_val, cpb_e, quarter, half_m1, full_m1, stop_m1;
    logic [3:0] nb, idx, pos;
    logic [WORD_W-1:0] word, word_nx;
    logic dbit, exp_bit, err_pend, last_bit, has_par, two_stop;
    par_mode_t pmode;
    stop_len_t slen;

    uaf_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .invert(cfg_line_inv), .lvl(lvl), .fall(fall)
    );

    uaf_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .tick(tick)
    );

    uaf_parity u_par (.word(word), .mode(pmode), .exp_bit(exp_bit));

    // Configuration decode
    assign pmode    = par_mode_t'(cfg_parity);
    assign slen     = stop_len_t'(cfg_stop);
    assign has_par  = (pmode != PAR_NONE);
    assign two_stop = (slen == STOP_TWO);
    assign nb       = (cfg_data_bits < 4'd5) ? 4'd5 :
                      (cfg_data_bits > 4'd9) ? 4'd9 : cfg_data_bits;
    assign cpb_e    = CNT_W'(cfg_clks_per_bit);
    assign quarter  = cpb_e >> 2;
    assign half_m1  = (cpb_e >> 1) - CNT_W'(1);
    assign full_m1  = cpb_e - CNT_W'(1);

    always_comb begin
        unique case (slen)
            STOP_HALF:     stop_m1 = cpb_e - quarter - CNT_W'(1);
            STOP_ONE_HALF: stop_m1 = cpb_e + quarter - CNT_W'(1);
            default:       stop_m1 = full_m1;
        endcase
    end

    // Data assembly
    assign dbit     = lvl ^ cfg_data_inv;
    assign last_bit = (idx == nb - 4'd1);
    assign pos      = cfg_msb_first ? (nb - 4'd1 - idx) : idx;

    always_comb begin
        word_nx      = word;
        word_nx[pos] = dbit;
    end

    // Next-state and timer control
    always_comb begin
        st_nx  = st;
        ld     = 1'b0;
        ld_val = full_m1;
        unique case (st)
            S_IDLE: begin
                if (fall) begin
                    st_nx  = S_START;
                    ld     = 1'b1;
                    ld_val = half_m1;
                end
            end
            S_START: begin
                if (tick) begin
                    ld    = 1'b1;
                    st_nx = lvl ? S_IDLE : S_DATA;
                end
            end
            S_DATA: begin
                if (tick) begin
                    ld = 1'b1;
                    if (last_bit) begin
                        if (has_par) begin
                            st_nx = S_PARITY;
                        end else begin
                            st_nx  = S_STOP1;
                            ld_val = stop_m1;
                        end
                    end
                end
            end
            S_PARITY: begin
                if (tick) begin
                    st_nx  = S_STOP1;
                    ld     = 1'b1;
                    ld_val = stop_m1;
                end
            end
            S_STOP1: begin
                if (tick) begin
                    ld    = 1'b1;
                    st_nx = (lvl && two_stop) ? S_STOP2 : S_IDLE;
                end
            end
            S_STOP2: begin
                if (tick) st_nx = S_IDLE;
            end
            default: st_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            word     <= '0;
            err_pend <= 1'b0;
        end else begin
            err_pend <= (st == S_PARITY) && tick && (exp_bit != dbit);
            if (st == S_START && tick) begin
                idx  <= '0;
                word <= '0;
            end else if (st == S_DATA && tick) begin
                idx  <= idx + 4'd1;
                word <= word_nx;
            end
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid   <= 1'b0;
            evt_code    <= EV_START;
            evt_data    <= '0;
            evt_dir     <= 1'b0;
            evt_par_exp <= 1'b0;
            evt_par_act <= 1'b0;
        end else begin
            evt_valid <= 1'b0;
            evt_dir   <= dir_in;
            if (err_pend) begin
                evt_valid <= 1'b1;
                evt_code  <= EV_PAR_ERR;
                evt_data  <= '0;
            end else if (tick) begin
                unique case (st)
                    S_START: begin
                        evt_valid <= 1'b1;
                        evt_code  <= lvl ? EV_BAD_START : EV_START;
                        evt_data  <= {8'd0, lvl};
                    end
                    S_DATA: begin
                        if (last_bit) begin
                            evt_valid <= 1'b1;
                            evt_code  <= EV_DATA;
                            evt_data  <= word_nx;
                        end
                    end
                    S_PARITY: begin
                        evt_valid   <= 1'b1;
                        evt_code    <= EV_PARITY;
                        evt_data    <= {8'd0, dbit};
                        evt_par_exp <= exp_bit;
                        evt_par_act <= dbit;
                    end
                    S_STOP1, S_STOP2: begin
                        evt_valid <= 1'b1;
                        evt_code  <= lvl ? EV_STOP : EV_BAD_STOP;
                        evt_data  <= {8'd0, lvl};
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !fall) |=> (st == S_IDLE));

    // R2
    start_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EV_START) |-> (evt_data == 9'd0));

    // R2
    bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EV_BAD_START) |-> (evt_data == 9'd1 && st == S_IDLE));

    // R3
    data_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EV_DATA) |-> ((evt_data >> nb) == 9'd0));

    // R6
    par_err_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EV_PAR_ERR) |->
        $past(evt_valid && evt_code == EV_PARITY));

    // R6
    par_err_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EV_PAR_ERR) |-> (evt_par_exp != evt_par_act));

    // R8
    bad_stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EV_BAD_STOP) |-> (st == S_IDLE));

    // R11
    dir_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_dir == $past(dir_in)));

    // R12
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_code != 3'd7));

endmodule

// File: tb/uart_frame_annotator_tb.sv
`timescale 1ns/1ps
module uart_frame_annotator_tb;
    localparam int CPB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line = 1'b1;
    logic [15:0] c_cpb = 16'(CPB);
    logic [3:0] c_bits = 4'd8;
    logic [2:0] c_par = 3'd0;
    logic [1:0] c_stop = 2'd1;
    logic c_msb = 1'b0, c_linv = 1'b0, c_dinv = 1'b0, c_dir = 1'b0;
    logic evt_valid, evt_dir, evt_par_exp, evt_par_act;
    logic [2:0] evt_code;
    logic [8:0] evt_data;

    int total = 0;
    int fails = 0;
    logic [14:0] got_q[$];
    logic [14:0] exp_q[$];

    always #2 clk = ~clk;

    uart_frame_annotator #(.CPB_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_in(line),
        .cfg_clks_per_bit(c_cpb), .cfg_data_bits(c_bits), .cfg_parity(c_par),
        .cfg_stop(c_stop), .cfg_msb_first(c_msb), .cfg_line_inv(c_linv),
        .cfg_data_inv(c_dinv), .dir_in(c_dir),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_data(evt_data),
        .evt_dir(evt_dir), .evt_par_exp(evt_par_exp), .evt_par_act(evt_par_act)
    );

    // Event monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && evt_valid)
            got_q.push_back({evt_code, evt_data, evt_dir,
                             (evt_code == 3'd6) ? {evt_par_exp, evt_par_act} : 2'b00});
    end

    function automatic logic [14:0] ev(input logic [2:0] code, input logic [8:0] d,
                                       input logic pe, input logic pa);
        return {code, d, c_dir, pe, pa};
    endfunction

    function automatic logic [8:0] mask_w(input logic [8:0] d);
        return d & 9'((1 << c_bits) - 1);
    endfunction

    function automatic logic exp_par(input logic [8:0] d);
        logic [8:0] m;
        m = mask_w(d);
        case (c_par)
            3'd1:    return ~^m;
            3'd2:    return ^m;
            3'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic drive(input logic v, input int cyc);
        @(posedge clk);
        line <= v ^ c_linv;
        repeat (cyc - 1) @(posedge clk);
    endtask

    task automatic send_frame(input logic [8:0] d, input bit bad_start,
                              input bit bad_stop, input bit flip_par);
        if (bad_start) begin
            drive(1'b0, 3);
            drive(1'b1, 3 * CPB);
            return;
        end
        drive(1'b0, CPB);
        for (int i = 0; i < int'(c_bits); i++) begin
            logic b;
            b = c_msb ? d[int'(c_bits) - 1 - i] : d[i];
            drive(b ^ c_dinv, CPB);
        end
        if (c_par != 3'd0) drive(exp_par(d) ^ flip_par ^ c_dinv, CPB);
        if (bad_stop) begin
            drive(1'b0, CPB);
            drive(1'b1, 2);
        end else begin
            case (c_stop)
                2'd0:    drive(1'b1, CPB / 2);
                2'd1:    drive(1'b1, CPB);
                2'd2:    drive(1'b1, CPB * 3 / 2);
                default: drive(1'b1, 2 * CPB);
            endcase
        end
    endtask

    task automatic expect_frame(input logic [8:0] d, input bit bad_start,
                                input bit bad_stop, input bit flip_par);
        logic p;
        if (bad_start) begin
            exp_q.push_back(ev(3'd4, 9'd1, 0, 0));
            return;
        end
        exp_q.push_back(ev(3'd0, 9'd0, 0, 0));
        exp_q.push_back(ev(3'd1, mask_w(d), 0, 0));
        if (c_par != 3'd0) begin
            p = exp_par(d) ^ flip_par;
            exp_q.push_back(ev(3'd2, {8'd0, p}, 0, 0));
            if (flip_par) exp_q.push_back(ev(3'd6, 9'd0, exp_par(d), p));
        end
        if (bad_stop) exp_q.push_back(ev(3'd5, 9'd0, 0, 0));
        else begin
            exp_q.push_back(ev(3'd3, 9'd1, 0, 0));
            if (c_stop == 2'd3) exp_q.push_back(ev(3'd3, 9'd1, 0, 0));
        end
    endtask

    task automatic compare(input string tag);
        repeat (3 * CPB) @(posedge clk);
        check({tag, " event count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check({tag, " event"}, 32'(got_q[i]), 32'(exp_q[i]));
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic one(input string tag, input logic [8:0] d, input bit bs,
                       input bit bp, input bit fp);
        expect_frame(d, bs, bp, fp);
        send_frame(d, bs, bp, fp);
        compare(tag);
    endtask

    task automatic set_cfg(input logic [3:0] b, input logic [2:0] p, input logic [1:0] s,
                           input logic m, input logic li, input logic di, input logic dr);
        @(posedge clk);
        c_bits <= b; c_par <= p; c_stop <= s; c_msb <= m;
        c_linv <= li; c_dinv <= di; c_dir <= dr;
        line <= 1'b1 ^ li;
        repeat (8) @(posedge clk);
    endtask

    task automatic t_reset_idle();
        @(negedge clk);
        check("R12 reset evt_valid", evt_valid, 0);
        repeat (5 * CPB) @(posedge clk);
        check("R1 idle produces no events", got_q.size(), 0);
    endtask

    task automatic t_basic();
        set_cfg(4'd8, 3'd0, 2'd1, 0, 0, 0, 0);
        one("R2 R3 R12 8-bit LSB-first 0xA5", 9'h0A5, 0, 0, 0);
        one("R3 8-bit 0x01", 9'h001, 0, 0, 0);
    endtask

    task automatic t_msb_even5();
        set_cfg(4'd5, 3'd2, 2'd1, 1, 0, 0, 0);
        one("R4 R5 5-bit MSB-first even", 9'h016, 0, 0, 0);
    endtask

    task automatic t_odd9();
        set_cfg(4'd9, 3'd1, 2'd1, 0, 0, 0, 0);
        one("R3 R5 9-bit odd", 9'h1C3, 0, 0, 0);
    endtask

    task automatic t_mark_space();
        set_cfg(4'd7, 3'd3, 2'd1, 0, 0, 0, 0);
        one("R5 mark parity", 9'h055, 0, 0, 0);
        set_cfg(4'd7, 3'd4, 2'd1, 0, 0, 0, 0);
        one("R5 space parity", 9'h02A, 0, 0, 0);
    endtask

    task automatic t_par_err();
        set_cfg(4'd8, 3'd2, 2'd1, 0, 0, 0, 0);
        one("R6 even parity mismatch", 9'h0F1, 0, 0, 1);
        set_cfg(4'd8, 3'd3, 2'd1, 0, 0, 0, 0);
        one("R6 mark parity mismatch", 9'h000, 0, 0, 1);
    endtask

    task automatic t_bad_stop();
        set_cfg(4'd8, 3'd0, 2'd3, 0, 0, 0, 0);
        one("R8 invalid stop", 9'h03C, 0, 1, 0);
    endtask

    task automatic t_bad_start();
        set_cfg(4'd8, 3'd0, 2'd1, 0, 0, 0, 0);
        one("R2 start glitch rejected at mid-bit", 9'h000, 1, 0, 0);
    endtask

    task automatic t_line_inv();
        set_cfg(4'd8, 3'd1, 2'd1, 0, 1, 0, 0);
        one("R9 whole-line inversion", 9'h0B4, 0, 0, 0);
    endtask

    task automatic t_data_inv();
        set_cfg(4'd6, 3'd2, 2'd1, 0, 0, 1, 0);
        one("R10 data-only inversion", 9'h02D, 0, 0, 0);
    endtask

    task automatic t_stop_lengths();
        set_cfg(4'd8, 3'd0, 2'd0, 0, 0, 0, 0);
        expect_frame(9'h081, 0, 0, 0);
        expect_frame(9'h07E, 0, 0, 0);
        send_frame(9'h081, 0, 0, 0);
        send_frame(9'h07E, 0, 0, 0);
        compare("R7 half stop back-to-back");
        set_cfg(4'd8, 3'd0, 2'd2, 0, 0, 0, 0);
        expect_frame(9'h0C3, 0, 0, 0);
        expect_frame(9'h03C, 0, 0, 0);
        send_frame(9'h0C3, 0, 0, 0);
        send_frame(9'h03C, 0, 0, 0);
        compare("R7 one-and-a-half stop back-to-back");
        set_cfg(4'd8, 3'd0, 2'd3, 0, 0, 0, 0);
        one("R7 two stop bits", 9'h099, 0, 0, 0);
    endtask

    task automatic t_dir();
        set_cfg(4'd8, 3'd1, 2'd1, 1, 0, 0, 1);
        one("R11 direction tag 1", 9'h0E7, 0, 0, 0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst_n <= 1'b1;
        t_reset_idle();
        t_basic();
        t_msb_even5();
        t_odd9();
        t_mark_space();
        t_par_err();
        t_bad_stop();
        t_bad_start();
        t_line_inv();
        t_data_inv();
        t_stop_lengths();
        t_dir();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule